// File: doc/BRIEF.md
# Register-Driven Byte SPI Master

This block is an SPI master that moves one byte per transfer. It has three active-low chip-select outputs and sits on a plain 32-bit register bus. Software sees two word locations. The first takes control words on write and returns status on read. The second holds the outgoing byte before a transfer and the incoming byte after it.

A transfer begins when a control word with the start bit set is written. The block clocks out eight bits, most significant first, in SPI mode 3: the clock idles high, each bit is launched on a falling edge and the input is captured on the following rising edge. Each half of the serial clock lasts (P+1) system cycles, where P is a five-bit field at the top of the control word. Software polls the busy flag and then reads the received byte. An internal loopback path feeds the master's own output back to its input, so a link can be tested without a device attached.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, all three chip selects are 1, SCLK is 1, MOSI is 1, status reads 0 and the data location reads 0.
- R2: Offset 0x0 accepts control writes and returns status on reads. In status, bit 1 is busy and all other bits are 0. Offset 0x4 holds the data byte in bits 7:0 and reads 0 in bits 31:8.
- R3: Writing control with bit 1 = 1 while idle starts a transfer. Busy reads 1 for exactly 16*(P+1) system cycles, where P is control bits 31:27.
- R4: Mode 3 framing: SCLK is 1 whenever busy is 0. The byte is sent most significant bit first, with MOSI changing on falling SCLK edges, so a device sampling on rising edges receives the byte that was transmitted.
- R5: Once busy is 0, the data location returns the eight bits sampled on the input on the rising SCLK edges, first sample in bit 7.
- R6: A control write while busy is ignored: the chip selects, prescaler and loopback keep their values, and the running transfer is neither restarted nor lengthened.
- R7: A data write during a transfer does not change the byte being shifted out. At the end of the transfer, the received byte replaces the written value.
- R8: While idle, MOSI holds the last bit it sent, which is bit 0 of the last transmitted byte.
- R9: With control bit 3 = 1, the received byte is taken from the master's own MOSI instead of the MISO pin, so it equals the transmitted byte.
- R10: Control bits 0, 2 and 4 drive chip-select outputs 0, 1 and 2 directly, active low. A control write with bit 1 = 0 changes only the settings and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Byte offset of the register access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 3 | Active-low chip selects |

## Verification
The bench measures the length of busy for prescaler values 0, 1, 3, 7 and 31. An off-by-one in the divider or in the edge count shows up as a transfer that is too short or too long. A device model on the pins checks bit order and sampling edge: a design that shifts LSB first, or samples on the wrong edge, delivers a shifted or reversed byte. Separate tests write control and data in the middle of a transfer. A design that restarts, rewrites the chip selects, or shifts the newly written byte fails these. Loopback is run with the MISO pin held at the opposite value, so a design that ignores bit 3 returns the wrong byte.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  // control word bit positions (fixed layout)
  localparam int CS0_BIT   = 0;
  localparam int START_BIT = 1;
  localparam int LOOP_BIT  = 3;
  localparam int BUSY_BIT  = 1;
  localparam int NUM_CS    = 3;

  // strobes from the sequencer to the shifter
  typedef struct packed {
    logic load;      // copy data byte into shifter
    logic fallEdge;  // SCLK goes low this cycle: launch next bit
    logic riseEdge;  // SCLK goes high this cycle: sample input
    logic done;      // last rising edge of the byte
  } shiftCmd_t;
endpackage

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
  import spi_mm_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int PRE_W = 5,
  parameter int BITS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [NUM_CS-1:0] csN,
  output logic              loopEn,
  output logic              busy,
  output logic              sclk,
  output shiftCmd_t         cmd
);
  localparam int EDGES  = 2 * BITS;
  localparam int EC_W   = $clog2(EDGES);
  localparam int PRE_LO = BUS_W - PRE_W;
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

  logic [PRE_W-1:0] prescale;
  logic [PRE_W-1:0] divCnt;
  logic [EC_W-1:0]  edgeCnt;
  logic             tick;
  logic             accept;

  assign accept = ctrlWr && !busy;
  assign tick   = busy && (divCnt == prescale);

  always_comb begin
    cmd.load     = accept && wrData[START_BIT];
    cmd.fallEdge = tick && sclk;
    cmd.riseEdge = tick && !sclk;
    cmd.done     = tick && !sclk && (edgeCnt == LAST_EDGE);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_cs
      always_ff @(posedge clk) begin
        if (!rstN)       csN[g] <= 1'b1;
        else if (accept) csN[g] <= wrData[CS0_BIT + 2*g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescale <= '0;
      loopEn   <= 1'b0;
      busy     <= 1'b0;
      sclk     <= 1'b1;
      divCnt   <= '0;
      edgeCnt  <= '0;
    end else if (accept) begin
      prescale <= wrData[BUS_W-1:PRE_LO];
      loopEn   <= wrData[LOOP_BIT];
      if (wrData[START_BIT]) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
      end
    end else if (busy) begin
      if (tick) begin
        divCnt  <= '0;
        sclk    <= ~sclk;
        edgeCnt <= edgeCnt + 1'b1;
        if (edgeCnt == LAST_EDGE) busy <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R4: clock parked high whenever no transfer runs
  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk);
  // R6: control writes during a transfer leave chip selects alone
  a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWr) |=> $stable(csN) && busy);
  // R3: the last sampling edge ends the transfer
  a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmd.done |=> !busy);
endmodule

// File: rtl/spi_mm_dpath.sv
module spi_mm_dpath
  import spi_mm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dataWr,
  input  logic [BITS-1:0] wrByte,
  input  shiftCmd_t       cmd,
  input  logic            loopEn,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rxByte
);
  logic [BITS-1:0] shiftReg;
  logic            sampleBit;

  assign sampleBit = loopEn ? mosi : miso;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      mosi     <= 1'b1;
      rxByte   <= '0;
    end else begin
      if (cmd.load)          shiftReg <= rxByte;
      else if (cmd.riseEdge) shiftReg <= {shiftReg[BITS-2:0], sampleBit};
      if (cmd.fallEdge)      mosi <= shiftReg[BITS-1];
      if (cmd.done)          rxByte <= {shiftReg[BITS-2:0], sampleBit};
      else if (dataWr)       rxByte <= wrByte;
    end
  end

  // R4: output bit only moves on a falling serial-clock strobe
  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.fallEdge) |=> $stable(mosi));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_mm_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 5,
  parameter int BITS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);

  logic      ctrlWr, dataWr, busy, loopEn;
  logic [BITS-1:0] rxByte;
  shiftCmd_t cmd;

  assign ctrlWr = busWr && (busAddr == CTRL_OFS);
  assign dataWr = busWr && (busAddr == DATA_OFS);

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_OFS)      busRdata[BUSY_BIT] = busy;
    else if (busAddr == DATA_OFS) busRdata[BITS-1:0] = rxByte;
  end

  spi_mm_ctrl #(.BUS_W(BUS_W), .PRE_W(PRE_W), .BITS(BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrData(busWdata),
    .csN(csN), .loopEn(loopEn), .busy(busy), .sclk(sclk), .cmd(cmd)
  );

  spi_mm_dpath #(.BITS(BITS)) i_dpath (
    .clk(clk), .rstN(rstN), .dataWr(dataWr), .wrByte(busWdata[BITS-1:0]),
    .cmd(cmd), .loopEn(loopEn), .miso(miso), .mosi(mosi), .rxByte(rxByte)
  );

  // R8: idle line holds its last bit
  a_r8_mosi_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(mosi));
endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, csN0, csN1, csN2;
  logic [2:0]  csN;
  logic        miso = 1'b0;
  int          errors = 0, checks = 0, cyc = 0, startCyc = 0;
  logic [7:0]  slaveOut = '0, slaveIn = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  // device model: launch on falling, capture on rising
  always @(negedge sclk) begin
    miso     <= slaveOut[7];
    slaveOut <= {slaveOut[6:0], 1'b0};
  end
  always @(posedge sclk) slaveIn <= {slaveIn[6:0], mosi};

  // {prescale, loopback, tx byte, device byte}
  localparam int NV = 5;
  localparam logic [21:0] VEC [NV] = '{
    {5'd0,  1'b0, 8'hA5, 8'h3C},
    {5'd3,  1'b0, 8'h01, 8'h80},
    {5'd0,  1'b1, 8'hC3, 8'h00},
    {5'd7,  1'b0, 8'hFF, 8'h5A},
    {5'd31, 1'b1, 8'h6E, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = 3'd0;
    startCyc = cyc;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata; busAddr = 3'd0;
  endtask

  task automatic waitIdle(output int len);
    logic [31:0] st;
    busRead(3'd0, st);
    while (st[1]) begin
      @(negedge clk);
      busRead(3'd0, st);
    end
    len = cyc - startCyc;
  endtask

  function automatic logic [31:0] ctrlWord(input logic [4:0] p, input logic lp,
                                           input logic go, input logic [2:0] cs);
    return {p, 22'd0, cs[2], lp, cs[1], go, cs[0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csN", {29'd0, csN}, 32'h7);
    check("R1 sclk", {31'd0, sclk}, 32'h1);
    check("R1 mosi", {31'd0, mosi}, 32'h1);
    busRead(3'd0, rd); check("R1 status", rd, 32'h0);
    busRead(3'd4, rd); check("R1 data", rd, 32'h0);

    // R10 chip select write without start
    busWrite(3'd0, ctrlWord(5'd0, 1'b0, 1'b0, 3'b101));
    check("R10 csN", {29'd0, csN}, 32'h5);
    busRead(3'd0, rd); check("R10 no start", rd, 32'h0);
    busWrite(3'd0, ctrlWord(5'd0, 1'b0, 1'b0, 3'b010));
    check("R10 csN", {29'd0, csN}, 32'h2);
    check("R10 sclk idle", {31'd0, sclk}, 32'h1);

    // table walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [4:0] p; logic lp; logic [7:0] tx, dv, expRx;
      {p, lp, tx, dv} = VEC[i];
      expRx = lp ? tx : dv;
      busWrite(3'd4, {24'hABCDEF, tx});
      busRead(3'd4, rd); check("R2 data readback", rd, {24'd0, tx});
      slaveOut = dv;
      busWrite(3'd0, ctrlWord(p, lp, 1'b1, 3'b110));
      busRead(3'd0, rd); check("R2 busy bit", rd, 32'h2);
      check("R10 csN during xfer", {29'd0, csN}, 32'h6);
      waitIdle(len);
      check("R3 busy length", len, 16 * (int'(p) + 1));
      check("R4 device received", {24'd0, slaveIn}, {24'd0, tx});
      check("R4 sclk idle", {31'd0, sclk}, 32'h1);
      busRead(3'd4, rd);
      check(lp ? "R9 loopback rx" : "R5 rx byte", rd, {24'd0, expRx});
      repeat (3) @(negedge clk);
      check("R8 mosi hold", {31'd0, mosi}, {31'd0, tx[0]});
    end

    // R6 control write during busy is ignored
    busWrite(3'd4, 32'h0000_0033);
    slaveOut = 8'h44;
    busWrite(3'd0, ctrlWord(5'd1, 1'b0, 1'b1, 3'b011));
    begin
      int s0;
      s0 = startCyc;
      repeat (6) @(negedge clk);
      busWrite(3'd0, ctrlWord(5'd0, 1'b1, 1'b1, 3'b100));
      check("R6 csN unchanged", {29'd0, csN}, 32'h3);
      startCyc = s0;
    end
    waitIdle(len);
    check("R6 length unchanged", len, 32);
    busRead(3'd4, rd); check("R6 loop not set", rd, 32'h44);

    // R7 data write during transfer
    busWrite(3'd4, 32'h0000_0096);
    slaveOut = 8'h11;
    busWrite(3'd0, ctrlWord(5'd0, 1'b0, 1'b1, 3'b110));
    repeat (4) @(negedge clk);
    busWrite(3'd4, 32'h0000_00FF);
    waitIdle(len);
    check("R7 shifted byte", {24'd0, slaveIn}, 32'h96);
    busRead(3'd4, rd); check("R7 rx replaces", rd, 32'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule